// File: doc/BRIEF.md
# Gridding Write-Hazard Issue Controller

This block decides which sample enters a multi-stage gridding read-modify-write pipeline next. Each sample carries a grid coordinate pair (u, v) and a tag. Its update touches a square footprint of side 2*SUPPORT+1 centred on that point. Two samples whose footprints overlap must never be inside the pipeline together, because the later read would miss the earlier write.

Each cycle the controller compares every candidate against the footprints held in a stage-occupancy shift register of PIPE_DEPTH entries. That register stands in for the gridding datapath. A candidate that conflicts is not issued. The controller parks it in a small deferral buffer and takes the next input sample. Parked samples are retried each cycle and have priority over new input. The oldest parked sample that is clear of every in-flight footprint goes first. An input is refused and a bubble is counted only when the buffer is full and that input still conflicts. A flush pulse blocks new input until the buffer and the pipeline are both empty.

Top module: `grid_hazard_issue`

## Requirements
- R1: After reset nothing is issued, both counters read zero, the buffer is empty and `in_ready_o` is high.
- R2: Two samples conflict exactly when |du| <= 2*SUPPORT and |dv| <= 2*SUPPORT. With SUPPORT=3, a distance of 7 on either axis is clear and a distance of 6 on both axes conflicts.
- R3: A non-conflicting input accepted at a clock edge appears on `iss_*` after that edge. Back-to-back clear inputs issue on consecutive cycles in arrival order.
- R4: A sample is issued only when its footprint overlaps no sample held in the PIPE_DEPTH occupancy stages. A sample stays in flight for PIPE_DEPTH cycles after it appears on `iss_*`.
- R5: A conflicting input is accepted and parked when the buffer has room. `defer_cnt_o` increases by one, and the next input is taken in the following cycle.
- R6: When nothing else competes, a parked sample appears on `iss_*` exactly PIPE_DEPTH+1 cycles after the sample blocking it appeared.
- R7: In a cycle where a parked sample issues, no input is accepted.
- R8: Among parked samples, the oldest one that is clear issues first. A younger clear entry overtakes an older blocked one.
- R9: When the buffer is full and the input conflicts, `stall_o` is high, `in_ready_o` is low, and `bubble_cnt_o` increases by one for each such cycle.
- R10: A flush pulse keeps `in_ready_o` low until the buffer is empty and no stage is occupied. The next input is then issued PIPE_DEPTH+2 cycles after the last parked sample.
- R11: Every accepted sample is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample present |
| in_u_i | input | COORD_W | Input u coordinate |
| in_v_i | input | COORD_W | Input v coordinate |
| in_tag_i | input | TAG_W | Input sample tag |
| in_ready_o | output | 1 | Input is taken at this edge when valid |
| flush_i | input | 1 | Drain request pulse |
| iss_valid_o | output | 1 | Sample entering the pipeline |
| iss_u_o | output | COORD_W | Issued u coordinate |
| iss_v_o | output | COORD_W | Issued v coordinate |
| iss_tag_o | output | TAG_W | Issued tag |
| stall_o | output | 1 | Bubble inserted this cycle |
| bubble_cnt_o | output | CNT_W | Bubbles inserted since reset |
| defer_cnt_o | output | CNT_W | Samples parked since reset |

## Verification
The bench targets the footprint edge at distances 6 and 7. A design with an off-by-one there would park a clear sample or issue an overlapping one. It also checks the exact retry cycle of a parked sample: a slow design shows up as a late issue, and a design that forgets the last stage shows up as an early one. A young clear entry must overtake an old blocked one, and a new input must wait while a parked sample issues; a FIFO-only buffer or an input-first arbiter reverses the observed issue order. Buffer-full stalls must give an exact bubble count, and a flush must hold input until the pipeline is fully drained. A leaky flush or a miscounted bubble changes the measured cycle gaps or counter deltas.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int unsigned COORD_W = 12;
  parameter int unsigned TAG_W   = 16;

  typedef struct packed {
    logic [COORD_W-1:0] u;
    logic [COORD_W-1:0] v;
    logic [TAG_W-1:0]   tag;
  } sample_t;

  function automatic logic fp_overlap(sample_t a, sample_t b, logic [COORD_W-1:0] reach);
    logic [COORD_W-1:0] du;
    logic [COORD_W-1:0] dv;
    du = (a.u > b.u) ? a.u - b.u : b.u - a.u;
    dv = (a.v > b.v) ? a.v - b.v : b.v - a.v;
    return (du <= reach) && (dv <= reach);
  endfunction
endpackage

// File: rtl/hzd_stage_track.sv
module hzd_stage_track
  import hzd_pkg::*;
#(
  parameter int unsigned DEPTH = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ins_valid_i,
  input  sample_t               ins_i,
  output logic [DEPTH-1:0]      stage_vld_o,
  output sample_t [DEPTH-1:0]   stage_o
);
  logic [DEPTH-1:0]    vld_q;
  sample_t [DEPTH-1:0] smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      smp_q <= '0;
    end else begin
      vld_q[0] <= ins_valid_i;
      smp_q[0] <= ins_valid_i ? ins_i : '0;
      for (int s = 1; s < DEPTH; s++) begin
        vld_q[s] <= vld_q[s-1];
        smp_q[s] <= smp_q[s-1];
      end
    end
  end

  assign stage_vld_o = vld_q;
  assign stage_o     = smp_q;
endmodule

// File: rtl/hzd_conflict_map.sv
module hzd_conflict_map
  import hzd_pkg::*;
#(
  parameter int unsigned N_CAND = 5,
  parameter int unsigned DEPTH  = 6,
  parameter logic [COORD_W-1:0] REACH = 6
) (
  input  sample_t [N_CAND-1:0] cand_i,
  input  logic [DEPTH-1:0]     stage_vld_i,
  input  sample_t [DEPTH-1:0]  stage_i,
  output logic [N_CAND-1:0]    conf_o
);
  for (genvar c = 0; c < N_CAND; c++) begin : g_cand
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int s = 0; s < DEPTH; s++) begin
        if (stage_vld_i[s] && fp_overlap(cand_i[c], stage_i[s], REACH)) hit = 1'b1;
      end
    end
    assign conf_o[c] = hit;
  end
endmodule

// File: rtl/hzd_park_buf.sv
module hzd_park_buf
  import hzd_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  sample_t             push_smp_i,
  input  logic                pop_i,
  input  logic [IW-1:0]       pop_idx_i,
  output sample_t [DEPTH-1:0] ent_o,
  output logic [CW-1:0]       cnt_o
);
  sample_t [DEPTH-1:0] ent_q;
  sample_t [DEPTH-1:0] shifted;
  sample_t [DEPTH-1:0] ent_d;
  logic [CW-1:0]       cnt_q;
  logic [CW-1:0]       wr_pos;

  // entries stay age ordered: index 0 is oldest
  assign shifted = ent_q >> $bits(sample_t);
  assign wr_pos  = cnt_q - CW'(pop_i);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_d[i] = (pop_i && (IW'(i) >= pop_idx_i)) ? shifted[i] : ent_q[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && (wr_pos == CW'(i))) ent_d[i] = push_smp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else begin
      ent_q <= ent_d;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign ent_o = ent_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/grid_hazard_issue.sv
module grid_hazard_issue
  import hzd_pkg::*;
#(
  parameter int unsigned SUPPORT    = 3,
  parameter int unsigned PIPE_DEPTH = 6,
  parameter int unsigned BUF_DEPTH  = 4,
  parameter int unsigned CNT_W      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [COORD_W-1:0] in_u_i,
  input  logic [COORD_W-1:0] in_v_i,
  input  logic [TAG_W-1:0]   in_tag_i,
  output logic               in_ready_o,
  input  logic               flush_i,
  output logic               iss_valid_o,
  output logic [COORD_W-1:0] iss_u_o,
  output logic [COORD_W-1:0] iss_v_o,
  output logic [TAG_W-1:0]   iss_tag_o,
  output logic               stall_o,
  output logic [CNT_W-1:0]   bubble_cnt_o,
  output logic [CNT_W-1:0]   defer_cnt_o
);
  localparam int unsigned BCW    = $clog2(BUF_DEPTH + 1);
  localparam int unsigned BIW    = $clog2(BUF_DEPTH);
  localparam int unsigned N_CAND = BUF_DEPTH + 1;
  localparam logic [COORD_W-1:0] REACH = COORD_W'(2 * SUPPORT);

  sample_t                  in_smp;
  sample_t [BUF_DEPTH-1:0]  buf_ent;
  logic [BCW-1:0]           buf_cnt;
  sample_t [N_CAND-1:0]     cand;
  logic [N_CAND-1:0]        conf;
  logic [PIPE_DEPTH-1:0]    stage_vld;
  sample_t [PIPE_DEPTH-1:0] stage;
  logic                     buf_pick;
  logic [BIW-1:0]           pick_idx;
  logic                     buf_full;
  logic                     in_conf;
  logic                     in_open;
  logic                     accept;
  logic                     park;
  logic                     ins_valid;
  sample_t                  ins_smp;
  logic                     flushing_q;
  logic [CNT_W-1:0]         bubble_q;
  logic [CNT_W-1:0]         defer_q;

  assign in_smp = '{u: in_u_i, v: in_v_i, tag: in_tag_i};
  assign cand   = {in_smp, buf_ent};

  hzd_conflict_map #(
    .N_CAND(N_CAND),
    .DEPTH (PIPE_DEPTH),
    .REACH (REACH)
  ) u_conf (
    .cand_i     (cand),
    .stage_vld_i(stage_vld),
    .stage_i    (stage),
    .conf_o     (conf)
  );

  // oldest clear parked entry wins
  always_comb begin
    buf_pick = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < BUF_DEPTH; i++) begin
      if (!buf_pick && (BCW'(i) < buf_cnt) && !conf[i]) begin
        buf_pick = 1'b1;
        pick_idx = BIW'(i);
      end
    end
  end

  assign buf_full   = (buf_cnt == BCW'(BUF_DEPTH));
  assign in_conf    = conf[BUF_DEPTH];
  assign in_open    = !flush_i && !flushing_q && !buf_pick;
  assign in_ready_o = in_open && (!in_conf || !buf_full);
  assign accept     = in_valid_i && in_ready_o;
  assign park       = accept && in_conf;
  assign stall_o    = in_valid_i && in_open && in_conf && buf_full;
  assign ins_valid  = buf_pick || (accept && !in_conf);
  assign ins_smp    = buf_pick ? buf_ent[pick_idx] : in_smp;

  hzd_park_buf #(
    .DEPTH(BUF_DEPTH)
  ) u_park (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (park),
    .push_smp_i(in_smp),
    .pop_i     (buf_pick),
    .pop_idx_i (pick_idx),
    .ent_o     (buf_ent),
    .cnt_o     (buf_cnt)
  );

  hzd_stage_track #(
    .DEPTH(PIPE_DEPTH)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_valid_i(ins_valid),
    .ins_i      (ins_smp),
    .stage_vld_o(stage_vld),
    .stage_o    (stage)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flushing_q <= 1'b0;
      bubble_q   <= '0;
      defer_q    <= '0;
    end else begin
      if (flush_i) flushing_q <= 1'b1;
      else if (flushing_q && (buf_cnt == '0) && (stage_vld == '0)) flushing_q <= 1'b0;
      if (stall_o) bubble_q <= bubble_q + CNT_W'(1);
      if (park)    defer_q  <= defer_q + CNT_W'(1);
    end
  end

  assign iss_valid_o  = stage_vld[0];
  assign iss_u_o      = stage[0].u;
  assign iss_v_o      = stage[0].v;
  assign iss_tag_o    = stage[0].tag;
  assign bubble_cnt_o = bubble_q;
  assign defer_cnt_o  = defer_q;
endmodule

// File: rtl/hzd_issue_chk.sv
module hzd_issue_chk
  import hzd_pkg::*;
#(
  parameter int unsigned SUPPORT    = 3,
  parameter int unsigned PIPE_DEPTH = 6,
  parameter int unsigned BUF_DEPTH  = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned BCW       = $clog2(BUF_DEPTH + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic                     stall_o,
  input logic                     buf_pick,
  input logic [BCW-1:0]           buf_cnt,
  input logic [PIPE_DEPTH-1:0]    stage_vld,
  input sample_t [PIPE_DEPTH-1:0] stage,
  input logic [CNT_W-1:0]         bubble_cnt_o,
  input logic [CNT_W-1:0]         defer_cnt_o
);
  logic overlap_hit;
  always_comb begin
    overlap_hit = 1'b0;
    for (int s = 1; s < PIPE_DEPTH; s++) begin
      if (stage_vld[0] && stage_vld[s]) begin
        if (((stage[0].u > stage[s].u ? stage[0].u - stage[s].u : stage[s].u - stage[0].u) <= COORD_W'(2*SUPPORT)) &&
            ((stage[0].v > stage[s].v ? stage[0].v - stage[s].v : stage[s].v - stage[0].v) <= COORD_W'(2*SUPPORT)))
          overlap_hit = 1'b1;
      end
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !overlap_hit);
  // R9
  stall_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (buf_cnt == BCW'(BUF_DEPTH)) && !in_ready_o);
  // R9
  bubble_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> bubble_cnt_o == $past(bubble_cnt_o) + CNT_W'(1));
  // R5
  defer_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (defer_cnt_o != $past(defer_cnt_o)) |-> defer_cnt_o == $past(defer_cnt_o) + CNT_W'(1));
  // R7
  park_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_pick |-> !(in_valid_i && in_ready_o));
  // R10
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !in_ready_o);
  // R1
  buf_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_cnt <= BCW'(BUF_DEPTH));
endmodule

bind grid_hazard_issue hzd_issue_chk #(
  .SUPPORT   (SUPPORT),
  .PIPE_DEPTH(PIPE_DEPTH),
  .BUF_DEPTH (BUF_DEPTH),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .stall_o     (stall_o),
  .buf_pick    (buf_pick),
  .buf_cnt     (buf_cnt),
  .stage_vld   (stage_vld),
  .stage       (stage),
  .bubble_cnt_o(bubble_cnt_o),
  .defer_cnt_o (defer_cnt_o)
);

// File: tb/grid_hazard_issue_bench.sv
`timescale 1ns/1ps
module grid_hazard_issue_bench;
  localparam int PD = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_u = '0;
  logic [11:0] in_v = '0;
  logic [15:0] in_tag = '0;
  logic        flush = 1'b0;
  logic        in_ready_o, iss_valid_o, stall_o;
  logic [11:0] iss_u_o, iss_v_o;
  logic [15:0] iss_tag_o;
  logic [15:0] bubble_cnt_o, defer_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int iss_cnt [256];
  int iss_cyc [256];
  int n_sent = 0;
  bit waited;

  always #2.5 clk = ~clk;

  grid_hazard_issue u_grid_hazard_issue (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_u_i(in_u), .in_v_i(in_v),
    .in_tag_i(in_tag), .in_ready_o(in_ready_o), .flush_i(flush), .iss_valid_o(iss_valid_o),
    .iss_u_o(iss_u_o), .iss_v_o(iss_v_o), .iss_tag_o(iss_tag_o), .stall_o(stall_o),
    .bubble_cnt_o(bubble_cnt_o), .defer_cnt_o(defer_cnt_o)
  );

  always @(posedge clk) begin
    cyc++;
    #1;
    if (iss_valid_o) begin
      iss_cnt[iss_tag_o[7:0]]++;
      iss_cyc[iss_tag_o[7:0]] = cyc;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int u, int v, int tag);
    waited = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_u = 12'(u); in_v = 12'(v); in_tag = 16'(tag);
    #1;
    while (!in_ready_o) begin
      waited = 1'b1;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    n_sent++;
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(iss_valid_o == 1'b0, "R1 issue", int'(iss_valid_o), 0);
    chk(bubble_cnt_o == 0 && defer_cnt_o == 0, "R1 counters", int'(bubble_cnt_o + defer_cnt_o), 0);
    chk(in_ready_o == 1'b1, "R1 ready", int'(in_ready_o), 1);
  endtask

  task automatic t_stream();
    int d0;
    d0 = int'(defer_cnt_o);
    send(10, 10, 1); send(30, 10, 2); send(50, 10, 3); send(70, 10, 4);
    idle(12);
    for (int t = 2; t <= 4; t++)
      chk(iss_cyc[t] - iss_cyc[t-1] == 1, "R3 consecutive", iss_cyc[t] - iss_cyc[t-1], 1);
    chk(int'(defer_cnt_o) == d0, "R3 no defer", int'(defer_cnt_o) - d0, 0);
  endtask

  task automatic t_boundary();
    int d0;
    d0 = int'(defer_cnt_o);
    send(300, 300, 10); send(307, 300, 11); send(300, 306, 12);
    idle(20);
    chk(iss_cyc[11] - iss_cyc[10] == 1, "R2 dist7 clear", iss_cyc[11] - iss_cyc[10], 1);
    chk(int'(defer_cnt_o) - d0 == 1, "R2 dist6 parks", int'(defer_cnt_o) - d0, 1);
    chk(iss_cyc[12] - iss_cyc[10] == PD + 1, "R2 dist6 waits", iss_cyc[12] - iss_cyc[10], PD + 1);
  endtask

  task automatic t_defer();
    int d0;
    d0 = int'(defer_cnt_o);
    send(600, 600, 20); send(603, 597, 21); send(900, 900, 22);
    idle(20);
    chk(int'(defer_cnt_o) - d0 == 1, "R5 defer count", int'(defer_cnt_o) - d0, 1);
    chk(iss_cyc[22] - iss_cyc[20] == 2, "R5 next input taken", iss_cyc[22] - iss_cyc[20], 2);
    chk(iss_cyc[21] - iss_cyc[20] == PD + 1, "R6 retry cycle", iss_cyc[21] - iss_cyc[20], PD + 1);
  endtask

  task automatic t_priority();
    send(200, 200, 30); send(0, 0, 31); send(2, 1, 32); send(201, 203, 33);
    idle(3);
    send(1000, 1000, 34);
    chk(waited == 1'b1, "R7 input held", int'(waited), 1);
    idle(20);
    chk(iss_cyc[33] - iss_cyc[30] == PD + 1, "R8 young clear entry", iss_cyc[33] - iss_cyc[30], PD + 1);
    chk(iss_cyc[32] - iss_cyc[33] == 1, "R8 old entry after", iss_cyc[32] - iss_cyc[33], 1);
    chk(iss_cyc[34] - iss_cyc[32] == 1, "R7 input after parked", iss_cyc[34] - iss_cyc[32], 1);
  endtask

  task automatic t_full();
    int b0, d0;
    b0 = int'(bubble_cnt_o); d0 = int'(defer_cnt_o);
    send(50, 50, 40);
    send(51, 50, 41); send(52, 50, 42); send(53, 51, 43); send(54, 52, 44);
    send(55, 50, 45);
    chk(waited == 1'b1, "R9 ready low when full", int'(waited), 1);
    idle(50);
    chk(int'(bubble_cnt_o) - b0 == 2, "R9 bubble count", int'(bubble_cnt_o) - b0, 2);
    chk(int'(defer_cnt_o) - d0 == 5, "R5 defer count full", int'(defer_cnt_o) - d0, 5);
    chk(iss_cyc[41] - iss_cyc[40] == PD + 1, "R6 first retry", iss_cyc[41] - iss_cyc[40], PD + 1);
    for (int t = 42; t <= 45; t++)
      chk(iss_cyc[t] - iss_cyc[t-1] >= PD + 1, "R4 no overlap in flight", iss_cyc[t] - iss_cyc[t-1], PD + 1);
  endtask

  task automatic t_flush();
    send(1500, 1500, 50); send(1501, 1501, 51);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    send(3000, 3000, 52);
    chk(waited == 1'b1, "R10 input held", int'(waited), 1);
    idle(12);
    chk(iss_cyc[52] - iss_cyc[51] == PD + 2, "R10 drain gap", iss_cyc[52] - iss_cyc[51], PD + 2);
  endtask

  task automatic t_once();
    int tot;
    tot = 0;
    for (int t = 0; t < 256; t++) begin
      if (iss_cnt[t] > 1) chk(1'b0, "R11 duplicate", iss_cnt[t], 1);
      tot += iss_cnt[t];
    end
    chk(tot == n_sent, "R11 all issued once", tot, n_sent);
  endtask

  initial begin
    for (int t = 0; t < 256; t++) begin iss_cnt[t] = 0; iss_cyc[t] = 0; end
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    idle(2);
    t_stream();
    t_boundary();
    t_defer();
    t_priority();
    t_full();
    t_flush();
    t_once();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule